// File: doc/BRIEF.md
# Descriptor Ring Poll Timer

This block sets the pace at which a DMA engine looks at its descriptor ring again. A 16-bit poll counter advances by one on every clock while the controller runs. When it passes FFFFh, the block raises a single-cycle poll request and reloads the counter from a 16-bit interval register. One instance serves the transmit ring and a second instance serves the receive ring.

The interval is written as the two's complement of the wanted period, with a seventeenth bit that is taken to be one. All sixteen stored bits therefore count as magnitude, and the period is 65536 minus the reload value. The four least significant interval bits take no part in the count, so the period moves in steps of 16 clocks. An init pulse clears the interval register and the counter, which gives the default period of 65536 clocks.

Software can read or write either register only while the controller is stopped or suspended. The two registers hold their contents through reset. Only the pulse output and the count enable are reset.

Top module: `ring_poll_timer`

## Requirements
- R1: While running, `poll_o` is high for exactly one clock. Consecutive pulses are 65536 − R clocks apart, where R is the interval with its low nibble cleared.
- R2: Interval bits [3:0] have no effect on the period. For example, FFF7h gives the same 16-clock period as FFF0h.
- R3: An interval of 0000h gives a period of 65536 clocks.
- R4: An `init_i` pulse sets both the interval and the counter to 0000h on the next edge. It takes priority over a register write in the same cycle.
- R5: A write (`reg_wr_i`) takes effect only while `stop_i` or `susp_i` is high. At any other time the write changes neither register.
- R6: While `stop_i` or `susp_i` is high, `reg_rdata_o` returns the selected register in bits [15:0]. The select is `reg_sel_i`: 0 picks the counter and 1 picks the interval. At any other time `reg_rdata_o` is zero.
- R7: Bits [31:16] of `reg_rdata_o` always read zero, and bits [31:16] of `reg_wdata_i` are ignored.
- R8: Asserting `rst_n` leaves the counter and the interval contents unchanged.
- R9: While `stop_i` or `susp_i` is high, the counter holds its value. When running resumes, counting continues from that held value.
- R10: The block counts when `run_i` is high, both `stop_i` and `susp_i` are low, and reset has been released for at least two clocks. On each such clock the counter rises by one, or reloads with R when it leaves FFFFh.
- R11: `poll_o` is low during reset and during any cycle that does not follow a counting clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| init_i | input | 1 | Initialisation pulse: clears the interval and the counter |
| stop_i | input | 1 | Controller stopped status |
| susp_i | input | 1 | Controller suspended status |
| run_i | input | 1 | Run enable for the counter |
| reg_sel_i | input | 1 | Register select: 0 selects the counter, 1 selects the interval |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Write data; only bits [15:0] are used |
| reg_rdata_o | output | 32 | Read data of the selected register, or zero when access is closed |
| poll_o | output | 1 | Single-cycle descriptor poll request |

## Verification
The properties assume that `init_i` is a single-clock pulse and that software touches the registers only through `reg_wr_i`. They also assume that the interval never goes above FFF0h in the upper twelve bits, so a poll pulse can never be followed at once by another. The stimulus drives every input half a clock after the falling edge and holds it stable across the next rising edge. It writes the registers only after an init pulse or an explicit write has made both values known. It changes `stop_i`, `susp_i` and `run_i` only on those same half-cycle points, including at and across counter wrap.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

  typedef enum logic {
    SEL_COUNT = 1'b0,
    SEL_IVAL  = 1'b1
  } rpt_sel_e;

endpackage

// File: rtl/rpt_rst_sync.sv
module rpt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/rpt_ival_reg.sv
module rpt_ival_reg
  import rpt_pkg::*;
#(
  parameter int unsigned REG_W    = 16,
  parameter int unsigned IGN_BITS = 4
) (
  input  logic             clk,
  input  logic             init_i,
  input  logic             acc_ok_i,
  input  logic             wr_i,
  input  rpt_sel_e         sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] ival_o,
  output logic [REG_W-1:0] reload_o
);

  logic [REG_W-1:0] ival_q;
  logic [REG_W-1:0] ival_d;
  logic             ival_en;

  always_comb begin
    ival_d  = ival_q;
    ival_en = 1'b0;
    if (init_i) begin
      ival_d  = '0;
      ival_en = 1'b1;
    end else if (acc_ok_i && wr_i && (sel_i == SEL_IVAL)) begin
      ival_d  = wdata_i;
      ival_en = 1'b1;
    end
  end

  // Contents survive every reset, so the register has none.
  always_ff @(posedge clk) begin
    if (ival_en) begin
      ival_q <= ival_d;
    end
  end

  generate
    if (IGN_BITS == 0) begin : g_full
      assign reload_o = ival_q;
    end else begin : g_masked
      assign reload_o = {ival_q[REG_W-1:IGN_BITS], {IGN_BITS{1'b0}}};
    end
  endgenerate

  assign ival_o = ival_q;

endmodule

// File: rtl/rpt_counter.sv
module rpt_counter #(
  parameter int unsigned REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en_i,
  input  logic             init_i,
  input  logic             load_i,
  input  logic [REG_W-1:0] load_val_i,
  input  logic [REG_W-1:0] reload_i,
  output logic [REG_W-1:0] cnt_o,
  output logic             poll_o
);

  localparam logic [REG_W-1:0] CNT_TOP = '1;

  logic [REG_W-1:0] cnt_q;
  logic [REG_W-1:0] cnt_d;
  logic             cnt_en;
  logic             wrap;
  logic             poll_q;

  always_comb begin
    wrap   = count_en_i && (cnt_q == CNT_TOP);
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (init_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (load_i) begin
      cnt_d  = load_val_i;
      cnt_en = 1'b1;
    end else if (count_en_i) begin
      cnt_d  = wrap ? reload_i : cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  // Counter value is kept across reset.
  always_ff @(posedge clk) begin
    if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_q <= 1'b0;
    end else begin
      poll_q <= wrap;
    end
  end

  assign cnt_o  = cnt_q;
  assign poll_o = poll_q;

endmodule

// File: rtl/ring_poll_timer.sv
module ring_poll_timer
  import rpt_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned REG_W      = 16,
  parameter int unsigned IGN_BITS   = 4,
  parameter int unsigned SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              stop_i,
  input  logic              susp_i,
  input  logic              run_i,
  input  logic              reg_sel_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              poll_o
);

  localparam int unsigned PAD_W = DATA_W - REG_W;

  logic             rst_s_n;
  logic             acc_ok;
  logic             count_en;
  logic             cnt_load;
  rpt_sel_e         sel;
  logic [REG_W-1:0] wdata_lo;
  logic [REG_W-1:0] ival_q;
  logic [REG_W-1:0] reload;
  logic [REG_W-1:0] cnt_q;
  logic [REG_W-1:0] rd_sel;

  assign sel      = rpt_sel_e'(reg_sel_i);
  assign wdata_lo = reg_wdata_i[REG_W-1:0];
  assign acc_ok   = stop_i | susp_i;
  assign count_en = run_i & ~acc_ok & rst_s_n;
  assign cnt_load = acc_ok & reg_wr_i & (sel == SEL_COUNT);

  rpt_rst_sync #(
    .STAGES(SYNC_STAGE)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_s_n)
  );

  rpt_ival_reg #(
    .REG_W   (REG_W),
    .IGN_BITS(IGN_BITS)
  ) u_ival (
    .clk     (clk),
    .init_i  (init_i),
    .acc_ok_i(acc_ok),
    .wr_i    (reg_wr_i),
    .sel_i   (sel),
    .wdata_i (wdata_lo),
    .ival_o  (ival_q),
    .reload_o(reload)
  );

  rpt_counter #(
    .REG_W(REG_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .count_en_i(count_en),
    .init_i    (init_i),
    .load_i    (cnt_load),
    .load_val_i(wdata_lo),
    .reload_i  (reload),
    .cnt_o     (cnt_q),
    .poll_o    (poll_o)
  );

  always_comb begin
    rd_sel = (sel == SEL_IVAL) ? ival_q : cnt_q;
    reg_rdata_o = acc_ok ? {{PAD_W{1'b0}}, rd_sel} : '0;
  end

endmodule

// File: rtl/rpt_checker.sv
module rpt_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_i,
  input logic              stop_i,
  input logic              susp_i,
  input logic              run_i,
  input logic              reg_sel_i,
  input logic              reg_wr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              poll_o,
  input logic              count_en,
  input logic [REG_W-1:0]  cnt_q,
  input logic [REG_W-1:0]  ival_q,
  input logic [REG_W-1:0]  reload
);

  logic seen_cnt;
  logic seen_ival;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_cnt  <= 1'b0;
      seen_ival <= 1'b0;
    end else begin
      if (init_i || ((stop_i || susp_i) && reg_wr_i && !reg_sel_i)) seen_cnt <= 1'b1;
      if (init_i || ((stop_i || susp_i) && reg_wr_i && reg_sel_i)) seen_ival <= 1'b1;
    end
  end

  AST_POLL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    poll_o |=> !poll_o); // R1

  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (ival_q == '0 && cnt_q == '0)); // R4

  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_ival && !stop_i && !susp_i && !init_i) |=> $stable(ival_q)); // R5

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[DATA_W-1:REG_W] == '0); // R7

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_cnt && (stop_i || susp_i) && !init_i && !reg_wr_i) |=> $stable(cnt_q)); // R9

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_cnt && count_en && !init_i && cnt_q != '1) |=> cnt_q == $past(cnt_q) + 1'b1); // R10

  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_cnt && seen_ival && poll_o) |-> cnt_q == reload); // R10

  AST_POLL_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    poll_o |-> $past(run_i && !stop_i && !susp_i)); // R11

endmodule

bind ring_poll_timer rpt_checker #(
  .DATA_W(DATA_W),
  .REG_W (REG_W)
) u_rpt_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .init_i     (init_i),
  .stop_i     (stop_i),
  .susp_i     (susp_i),
  .run_i      (run_i),
  .reg_sel_i  (reg_sel_i),
  .reg_wr_i   (reg_wr_i),
  .reg_rdata_o(reg_rdata_o),
  .poll_o     (poll_o),
  .count_en   (count_en),
  .cnt_q      (cnt_q),
  .ival_q     (ival_q),
  .reload     (reload)
);

// File: tb/ring_poll_timer_bench.sv
`timescale 1ns/100ps
module ring_poll_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_i = 1'b0;
  logic        stop_i = 1'b1;
  logic        susp_i = 1'b0;
  logic        run_i = 1'b0;
  logic        reg_sel_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        poll_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_cnt = 0;
  int m_ival = 0;
  bit m_poll = 1'b0;
  bit m_known = 1'b0;
  int m_age = 0;

  always #2 clk = ~clk;

  ring_poll_timer u_ring_poll_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (init_i),
    .stop_i     (stop_i),
    .susp_i     (susp_i),
    .run_i      (run_i),
    .reg_sel_i  (reg_sel_i),
    .reg_wr_i   (reg_wr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .poll_o     (poll_o)
  );

  task automatic check(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // reference model, one step per rising edge
  always @(posedge clk) begin
    bit acc;
    bit cen;
    acc = stop_i || susp_i;
    cen = run_i && !acc && (m_age >= 2) && rst_n;
    m_poll = cen && (m_cnt == 32'hFFFF);
    if (init_i) begin
      m_cnt = 0; m_ival = 0; m_known = 1'b1;
    end else begin
      if (acc && reg_wr_i && reg_sel_i) m_ival = int'(reg_wdata_i[15:0]);
      if (acc && reg_wr_i && !reg_sel_i) m_cnt = int'(reg_wdata_i[15:0]);
      else if (cen) m_cnt = (m_cnt == 32'hFFFF) ? (m_ival & 32'hFFF0) : m_cnt + 1;
    end
    if (!rst_n) begin m_age = 0; m_poll = 1'b0; end
    else if (m_age < 2) m_age++;
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      check("R1/R11 poll_o", poll_o, m_poll);
      if (m_known) begin
        if (stop_i || susp_i)
          check("R6 rdata", reg_rdata_o, reg_sel_i ? m_ival : m_cnt);
        else
          check("R6 rdata closed", reg_rdata_o, 0);
      end
      if (cycles > 190000) begin
        failures++;
        $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
        done = 1'b1;
        finish_run();
      end
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(negedge clk); #0.5; end
  endtask

  task automatic write_reg(bit sel, logic [31:0] data);
    reg_sel_i = sel; reg_wdata_i = data; reg_wr_i = 1'b1;
    tick(1);
    reg_wr_i = 1'b0;
  endtask

  task automatic read_chk(string tag, bit sel, int exp);
    reg_sel_i = sel;
    #0.5;
    check(tag, reg_rdata_o, exp);
  endtask

  task automatic wait_poll(output int n);
    n = 0;
    do begin tick(1); n++; end while (!poll_o && n < 70000);
  endtask

  task automatic go();  stop_i = 1'b0; susp_i = 1'b0; run_i = 1'b1; endtask
  task automatic halt(); stop_i = 1'b1; run_i = 1'b0; endtask

  initial begin
    int n;
    tick(3);
    check("R11 poll in reset", poll_o, 0);
    rst_n = 1'b1;
    tick(3);
    // R4: init beats a same-cycle write
    init_i = 1'b1; reg_sel_i = 1'b1; reg_wdata_i = 32'h1230; reg_wr_i = 1'b1;
    tick(1);
    init_i = 1'b0; reg_wr_i = 1'b0;
    read_chk("R4 ival after init", 1, 0);
    read_chk("R4 cnt after init", 0, 0);

    // R7: upper write bits dropped
    write_reg(1, 32'hDEAD_FFF0);
    read_chk("R7 upper bits", 1, 32'h0000FFF0);

    // R1: period 16
    write_reg(0, 32'h0000FFF0);
    go();
    wait_poll(n); check("R1 first period", n, 16);
    wait_poll(n); check("R1 period", n, 16);
    tick(1);
    check("R1 pulse width", poll_o, 0);
    halt(); tick(1);

    // R2: low nibble ignored
    write_reg(1, 32'h0000FFF7);
    write_reg(0, 32'h0000FFF0);
    go();
    wait_poll(n); wait_poll(n); check("R2 period with low bits", n, 16);
    halt(); tick(1);
    write_reg(1, 32'h0000FF0F);
    write_reg(0, 32'h0000FFFF);
    go();
    wait_poll(n); check("R1 wrap at FFFF", n, 1);
    wait_poll(n); check("R1 period 256", n, 256);
    halt(); tick(1);

    // R10, R9: step counting, freeze, resume
    write_reg(0, 32'h00001234);
    go(); tick(5); halt(); tick(1);
    read_chk("R10 counted five", 0, 32'h1239);
    stop_i = 1'b0; susp_i = 1'b1; run_i = 1'b1; tick(10);
    read_chk("R9 frozen in suspend", 0, 32'h1239);
    go(); tick(3); halt(); tick(1);
    read_chk("R9 resumed", 0, 32'h123C);

    // R5: writes while running ignored
    go();
    reg_sel_i = 1'b1; reg_wdata_i = 32'hABC0; reg_wr_i = 1'b1; tick(1);
    reg_sel_i = 1'b0; reg_wdata_i = 32'h0005; tick(1);
    reg_wr_i = 1'b0;
    check("R6 closed read", reg_rdata_o, 0);
    halt(); tick(1);
    read_chk("R5 ival kept", 1, 32'hFF0F);
    read_chk("R5 cnt only counted", 0, 32'h123E);

    // R8: reset keeps contents
    write_reg(0, 32'h5A5A);
    write_reg(1, 32'hC3C0);
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(1);
    read_chk("R8 cnt kept", 0, 32'h5A5A);
    read_chk("R8 ival kept", 1, 32'hC3C0);

    // R11: no pulse while stopped at FFFF, none in reset-release window
    write_reg(0, 32'hFFFF);
    tick(5);
    check("R11 stopped at top", poll_o, 0);
    rst_n = 1'b0; tick(1); go(); rst_n = 1'b1;
    tick(2);
    check("R11 release window", poll_o, 0);
    tick(1);
    check("R11 first count after release", poll_o, 1);
    halt(); tick(1);

    // R3: default period
    init_i = 1'b1; tick(1); init_i = 1'b0;
    go();
    wait_poll(n); check("R3 period 65536", n, 65536);
    halt(); tick(2);

    done = 1'b1;
    finish_run();
  end

endmodule